// File: doc/BRIEF.md
# Panel Power-Up Sequencer

This block brings a small display panel out of reset after a single start pulse. It first shapes a timed pulse on the panel's active-low reset pin. It then asks an external word serializer to read one identification byte from the panel. On the value of that byte it picks one of two bring-up programs held in an internal ROM, and it plays the chosen program one entry at a time. Each entry is a command word followed by its parameter words, and an optional wait in milliseconds comes after the entry. The run ends with two fixed commands: the first switches the display on and the second takes the panel out of sleep.

Every word goes to the serializer through a request/acknowledge handshake. A flag with the word marks it as a command or a parameter, and a second flag marks the identification read. A failed transfer is one the serializer flags as bad or one it never acknowledges. Such a failure does not stop the run. It sets a sticky error flag, and the block still reports done at the end. A prescaler parameter turns the system clock into a millisecond time base, so a test can shrink every delay by the same factor.

Top module: `lcd_init_seq`

## Requirements
- R1: After reset, panel_rst_n is 1, ser_req is 0, and done and error are both 0.
- R2: A start pulse in idle keeps panel_rst_n high for RST_HI_MS ms (100), then drives it low for RST_LO_MS ms (40), then high for RST_HI_MS ms (100). No request is raised before that last interval ends, and none is raised while panel_rst_n is low.
- R3: The first transfer is the identification read, with ser_rd=1, ser_dc=0 and ser_data=0x04. The byte returned on ser_rdata with the acknowledge picks the first program when it equals 0x80. Any other value picks the second program, and so does a failed read.
- R4: The first program sends the commands 0x36, 0x3A, 0xB6, 0xC5, 0xE0, 0xE1, 0xB0, 0xB4 in that order. Every run, whichever program it played, then ends with 0x29 followed by 0x11.
- R5: Command words carry ser_dc=0 and parameter words carry ser_dc=1. In the first program the commands carry 1, 1, 4, 2, 16, 16, 1 and 1 parameters in the order of R4. 0x29 and 0x11 carry none.
- R6: The second program has 22 commands and 108 parameter words. It opens with 0xFF and its parameters 0xFF, 0x98, 0x06, and it closes with 0x35 and a single parameter 0x00.
- R7: A 20 ms wait follows the 0xE1 entry of the first program. A 100 ms wait follows its 0xB4 entry, and a 100 ms wait follows 0x29. No other entry, in either program, is followed by a wait.
- R8: ser_req stays high with ser_data, ser_dc and ser_rd unchanged until ser_ack or watchdog expiry, and it is low in the cycle after an acknowledge.
- R9: done rises after 0x11 completes and stays high, with ser_req low, until the next start.
- R10: A word acknowledged with ser_err=1 skips the remaining parameters of its entry. The entry's wait still runs, the run goes on with the next entry, and error is set. error stays set until the next start clears it.
- R11: A request that gets no acknowledge within WD_CYCLES cycles is withdrawn and handled as a failed transfer, as in R10.
- R12: A start pulse while a run is in progress has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a bring-up run |
| panel_rst_n | output | 1 | Active-low reset pin of the panel |
| ser_req | output | 1 | Word request to the serializer |
| ser_rd | output | 1 | Marks the request as the identification read |
| ser_dc | output | 1 | 0 for a command word, 1 for a parameter word |
| ser_data | output | 8 | Word to send |
| ser_ack | input | 1 | One-cycle pulse: the requested word is finished |
| ser_err | input | 1 | Qualifies ser_ack: the transfer failed |
| ser_rdata | input | 8 | Byte read back, valid with ser_ack on a read |
| done | output | 1 | Run complete, held until the next start |
| error | output | 1 | Sticky flag: at least one transfer failed |

## Verification
Runs with the identification byte equal to 0x80 and equal to another value show that the program is chosen by the byte read back. They check the full command order, the parameter counts, and the first and last entries of each program. The spacing between each acknowledge and the next command tells the entries that carry a wait, and the length of that wait, apart from those that carry none. The spacing of the reset pin edges measures the reset pulse. An error injected on a command word, and a command word that is never acknowledged, both show the remaining parameters being skipped while the rest of the run, the sticky flag and done behave as specified. A second start pulse issued mid-run must leave the word count unchanged.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  localparam int ENT_AW = 5;
  localparam int PAR_AW = 8;
  localparam int NPARAM = 150;
  localparam int MS_W   = 8;

  localparam logic [ENT_AW-1:0] SEQA_BASE  = 5'd0;
  localparam logic [ENT_AW-1:0] SEQA_LAST  = 5'd7;
  localparam logic [ENT_AW-1:0] SEQB_BASE  = 5'd8;
  localparam logic [ENT_AW-1:0] TRAIL_BASE = 5'd30;
  localparam logic [ENT_AW-1:0] ENT_LAST   = 5'd31;

  localparam logic [7:0] ID_SEQA  = 8'h80;
  localparam logic [7:0] RDID_CMD = 8'h04;

  typedef struct packed {
    logic [7:0] cmd;
    logic [4:0] cnt;
    logic [6:0] dly;
    logic [7:0] off;
  } entry_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RHI1, S_RLO, S_RHI2, S_RDID,
    S_CMD, S_XFER, S_PAR, S_END, S_WAIT, S_NEXT
  } seq_state_t;

endpackage

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int CLKS_PER_MS = 50000,
  parameter int MS_W        = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MS_W-1:0] ms,
  output logic            expired
);
  localparam int PW = $clog2(CLKS_PER_MS + 1);

  logic [PW-1:0]   pre;
  logic [MS_W-1:0] ms_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre     <= '0;
      ms_left <= '0;
    end else if (load) begin
      pre     <= '0;
      ms_left <= ms;
    end else if (ms_left != '0) begin
      if (pre == PW'(CLKS_PER_MS - 1)) begin
        pre     <= '0;
        ms_left <= ms_left - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign expired = !load && (ms_left == '0);
endmodule

// File: rtl/lcd_init_rom.sv
module lcd_init_rom
  import lcd_init_pkg::*;
(
  input  logic [ENT_AW-1:0] eidx,
  output entry_t            ent,
  input  logic [PAR_AW-1:0] paddr,
  output logic [7:0]        pbyte
);
  // Parameter bytes, byte 0 in the leftmost position.
  localparam logic [511:0] BANK0 = 512'h086622e2ff04006a_00070d1013190f0c_050806130f30201f_1f20300f13060805_0c0f1913100d0700_0102ff9806600110_617401011b127100_000001010500fff2;
  localparam logic [511:0] BANK1 = 512'h0100400123456701_234567012222badc_26282222747f0f00_030b0008a0000000_0000207400000082_0013138005402817_757920006600030b_0c0e08c504080c13;
  localparam logic [175:0] BANK2 = 176'h1111140c10000d11_0c0c047603080b16_100d160a0000;
  localparam logic [NPARAM*8-1:0] PROM = {BANK0, BANK1, BANK2};

  // Entry fields: command, parameter count, wait in ms, parameter offset.
  always_comb begin
    case (eidx)
      5'd0:  ent = '{8'h36, 5'd1,  7'd0,   8'd0};
      5'd1:  ent = '{8'h3A, 5'd1,  7'd0,   8'd1};
      5'd2:  ent = '{8'hB6, 5'd4,  7'd0,   8'd2};
      5'd3:  ent = '{8'hC5, 5'd2,  7'd0,   8'd6};
      5'd4:  ent = '{8'hE0, 5'd16, 7'd0,   8'd8};
      5'd5:  ent = '{8'hE1, 5'd16, 7'd20,  8'd24};
      5'd6:  ent = '{8'hB0, 5'd1,  7'd0,   8'd40};
      5'd7:  ent = '{8'hB4, 5'd1,  7'd100, 8'd41};
      5'd8:  ent = '{8'hFF, 5'd3,  7'd0,   8'd42};
      5'd9:  ent = '{8'hBA, 5'd1,  7'd0,   8'd45};
      5'd10: ent = '{8'hBC, 5'd21, 7'd0,   8'd46};
      5'd11: ent = '{8'hBD, 5'd8,  7'd0,   8'd67};
      5'd12: ent = '{8'hBE, 5'd9,  7'd0,   8'd75};
      5'd13: ent = '{8'hC7, 5'd1,  7'd0,   8'd84};
      5'd14: ent = '{8'hED, 5'd3,  7'd0,   8'd85};
      5'd15: ent = '{8'hC0, 5'd3,  7'd0,   8'd88};
      5'd16: ent = '{8'hFC, 5'd1,  7'd0,   8'd91};
      5'd17: ent = '{8'hB6, 5'd1,  7'd0,   8'd92};
      5'd18: ent = '{8'hDF, 5'd6,  7'd0,   8'd93};
      5'd19: ent = '{8'hF3, 5'd1,  7'd0,   8'd99};
      5'd20: ent = '{8'hB4, 5'd3,  7'd0,   8'd100};
      5'd21: ent = '{8'hF7, 5'd1,  7'd0,   8'd103};
      5'd22: ent = '{8'hB1, 5'd3,  7'd0,   8'd104};
      5'd23: ent = '{8'hF2, 5'd4,  7'd0,   8'd107};
      5'd24: ent = '{8'hC1, 5'd4,  7'd0,   8'd111};
      5'd25: ent = '{8'h36, 5'd1,  7'd0,   8'd115};
      5'd26: ent = '{8'h3A, 5'd1,  7'd0,   8'd116};
      5'd27: ent = '{8'hE0, 5'd16, 7'd0,   8'd117};
      5'd28: ent = '{8'hE1, 5'd16, 7'd0,   8'd133};
      5'd29: ent = '{8'h35, 5'd1,  7'd0,   8'd149};
      5'd30: ent = '{8'h29, 5'd0,  7'd100, 8'd0};
      default: ent = '{8'h11, 5'd0, 7'd0,  8'd0};
    endcase
  end

  always_comb begin
    if (int'(paddr) < NPARAM) pbyte = PROM[(NPARAM - 1 - int'(paddr))*8 +: 8];
    else                      pbyte = 8'h00;
  end
endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000,
  parameter int WD_CYCLES   = 4096,
  parameter int RST_HI_MS   = 100,
  parameter int RST_LO_MS   = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       panel_rst_n,
  output logic       ser_req,
  output logic       ser_rd,
  output logic       ser_dc,
  output logic [7:0] ser_data,
  input  logic       ser_ack,
  input  logic       ser_err,
  input  logic [7:0] ser_rdata,
  output logic       done,
  output logic       error
);
  localparam int WDW = $clog2(WD_CYCLES + 1);

  seq_state_t        st;
  logic [ENT_AW-1:0] eidx;
  entry_t            ent;
  logic [PAR_AW-1:0] paddr;
  logic [7:0]        pbyte;
  logic [4:0]        pleft;
  logic [WDW-1:0]    wd_cnt;
  logic              wd_exp;
  logic              xfer_end;
  logic              xfer_fail;
  logic              tmr_load;
  logic [MS_W-1:0]   tmr_ms;
  logic              tmr_exp;

  lcd_init_rom u_rom (
    .eidx  (eidx),
    .ent   (ent),
    .paddr (paddr),
    .pbyte (pbyte)
  );

  lcd_ms_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MS_W(MS_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .ms      (tmr_ms),
    .expired (tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst || !ser_req) wd_cnt <= '0;
    else                 wd_cnt <= wd_cnt + 1'b1;
  end

  assign wd_exp    = ser_req && (wd_cnt == WDW'(WD_CYCLES - 1));
  assign xfer_end  = ser_ack || wd_exp;
  assign xfer_fail = !ser_ack || ser_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      panel_rst_n <= 1'b1;
      ser_req     <= 1'b0;
      ser_rd      <= 1'b0;
      ser_dc      <= 1'b0;
      ser_data    <= '0;
      done        <= 1'b0;
      error       <= 1'b0;
      eidx        <= '0;
      paddr       <= '0;
      pleft       <= '0;
      tmr_load    <= 1'b0;
      tmr_ms      <= '0;
    end else begin
      tmr_load <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          done     <= 1'b0;
          error    <= 1'b0;
          tmr_load <= 1'b1;
          tmr_ms   <= MS_W'(RST_HI_MS);
          st       <= S_RHI1;
        end
        S_RHI1: if (tmr_exp) begin
          panel_rst_n <= 1'b0;
          tmr_load    <= 1'b1;
          tmr_ms      <= MS_W'(RST_LO_MS);
          st          <= S_RLO;
        end
        S_RLO: if (tmr_exp) begin
          panel_rst_n <= 1'b1;
          tmr_load    <= 1'b1;
          tmr_ms      <= MS_W'(RST_HI_MS);
          st          <= S_RHI2;
        end
        S_RHI2: if (tmr_exp) begin
          ser_req  <= 1'b1;
          ser_rd   <= 1'b1;
          ser_dc   <= 1'b0;
          ser_data <= RDID_CMD;
          st       <= S_RDID;
        end
        S_RDID: if (xfer_end) begin
          ser_req <= 1'b0;
          ser_rd  <= 1'b0;
          if (!xfer_fail && ser_rdata == ID_SEQA) eidx <= SEQA_BASE;
          else                                    eidx <= SEQB_BASE;
          if (xfer_fail) error <= 1'b1;
          st <= S_CMD;
        end
        S_CMD: begin
          ser_req  <= 1'b1;
          ser_dc   <= 1'b0;
          ser_data <= ent.cmd;
          pleft    <= ent.cnt;
          paddr    <= ent.off;
          st       <= S_XFER;
        end
        S_XFER: if (xfer_end) begin
          ser_req <= 1'b0;
          if (xfer_fail) begin
            error <= 1'b1;
            st    <= S_END;
          end else if (pleft != '0) begin
            st <= S_PAR;
          end else begin
            st <= S_END;
          end
        end
        S_PAR: begin
          ser_req  <= 1'b1;
          ser_dc   <= 1'b1;
          ser_data <= pbyte;
          paddr    <= paddr + 1'b1;
          pleft    <= pleft - 1'b1;
          st       <= S_XFER;
        end
        S_END: if (ent.dly != '0) begin
          tmr_load <= 1'b1;
          tmr_ms   <= MS_W'(ent.dly);
          st       <= S_WAIT;
        end else begin
          st <= S_NEXT;
        end
        S_WAIT: if (tmr_exp) st <= S_NEXT;
        S_NEXT: begin
          if (eidx == ENT_LAST) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            eidx <= (eidx == SEQA_LAST) ? TRAIL_BASE : eidx + 1'b1;
            st   <= S_CMD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk #(
  parameter int WD_CYCLES = 4096
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       panel_rst_n,
  input logic       ser_req,
  input logic       ser_rd,
  input logic       ser_dc,
  input logic [7:0] ser_data,
  input logic       ser_ack,
  input logic       done,
  input logic       error
);
  int req_age;

  always_ff @(posedge clk) begin
    if (rst || !ser_req) req_age <= 0;
    else                 req_age <= req_age + 1;
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ser_req && !ser_ack && req_age < WD_CYCLES - 1) |=>
      (ser_req && $stable(ser_data) && $stable(ser_dc) && $stable(ser_rd)));

  assert_req_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (ser_req && ser_ack) |=> !ser_req);

  assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
    !panel_rst_n |-> !ser_req);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !ser_req);

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(start));

  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(error) |-> $past(start));

  assert_watchdog_R11: assert property (@(posedge clk) disable iff (rst)
    ser_req |-> (req_age < WD_CYCLES));
endmodule

bind lcd_init_seq lcd_init_seq_chk #(.WD_CYCLES(WD_CYCLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .panel_rst_n (panel_rst_n),
  .ser_req     (ser_req),
  .ser_rd      (ser_rd),
  .ser_dc      (ser_dc),
  .ser_data    (ser_data),
  .ser_ack     (ser_ack),
  .done        (done),
  .error       (error)
);

// File: tb/tb_lcd_init_seq.sv
`timescale 1ns/1ps
module tb_lcd_init_seq;
  localparam int C       = 10;
  localparam int WD      = 40;
  localparam int ACK_LAT = 3;

  logic clk = 1'b0;
  logic rst, start;
  logic panel_rst_n, ser_req, ser_rd, ser_dc, done, error;
  logic [7:0] ser_data;
  logic ser_ack, ser_err;
  logic [7:0] ser_rdata;

  always #10 clk = ~clk;

  lcd_init_seq #(.CLKS_PER_MS(C), .WD_CYCLES(WD)) dut (
    .clk(clk), .rst(rst), .start(start), .panel_rst_n(panel_rst_n),
    .ser_req(ser_req), .ser_rd(ser_rd), .ser_dc(ser_dc), .ser_data(ser_data),
    .ser_ack(ser_ack), .ser_err(ser_err), .ser_rdata(ser_rdata),
    .done(done), .error(error)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // serializer model and word log
  logic [7:0] lg_data [0:255];
  bit  lg_dc [0:255];
  bit  lg_rd [0:255];
  bit  lg_hung [0:255];
  int  lg_req [0:255];
  int  lg_ack [0:255];
  int  nlog = 0;
  int  err_at = -1, hang_at = -1;
  logic [7:0] panel_id = 8'h80;
  bit  srv_busy = 0;
  int  srv_wait = 0;

  initial begin
    ser_ack = 0; ser_err = 0; ser_rdata = 0;
    forever begin
      @(negedge clk);
      ser_ack = 0; ser_err = 0;
      if (srv_busy) begin
        if (!ser_req) begin
          lg_ack[nlog] = cyc; lg_hung[nlog] = 1;
          if (nlog < 255) nlog++;
          srv_busy = 0;
        end else begin
          srv_wait++;
          if (srv_wait >= ACK_LAT && nlog != hang_at) begin
            ser_ack = 1; ser_err = (nlog == err_at); ser_rdata = panel_id;
            lg_ack[nlog] = cyc; lg_hung[nlog] = 0;
            if (nlog < 255) nlog++;
            srv_busy = 0;
          end
        end
      end else if (ser_req) begin
        srv_busy = 1; srv_wait = 0;
        lg_data[nlog] = ser_data; lg_dc[nlog] = ser_dc; lg_rd[nlog] = ser_rd;
        lg_req[nlog] = cyc;
      end
    end
  end

  // reset pin edge monitor
  int fall_c = -1, rise_c = -1, start_c = 0;
  logic prev_rst_n = 1'b1;
  initial forever begin
    @(negedge clk);
    if (panel_rst_n !== prev_rst_n) begin
      if (panel_rst_n === 1'b0) fall_c = cyc; else rise_c = cyc;
      prev_rst_n = panel_rst_n;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // command list parsed from the log
  int ncmd;
  int cmd_v [0:63];
  int cmd_n [0:63];
  int cmd_w [0:63];
  int cmd_last [0:63];

  task automatic parse();
    ncmd = 0;
    for (int i = 1; i < nlog; i++) begin
      if (!lg_dc[i]) begin
        if (ncmd < 64) begin
          cmd_v[ncmd] = int'(lg_data[i]); cmd_n[ncmd] = 0;
          cmd_w[ncmd] = i; cmd_last[ncmd] = i; ncmd++;
        end
      end else if (ncmd > 0) begin
        cmd_n[ncmd-1]++; cmd_last[ncmd-1] = i;
      end
    end
  endtask

  task automatic run(input logic [7:0] id, input int e_at, input int h_at, input bit poke);
    nlog = 0; err_at = e_at; hang_at = h_at; panel_id = id;
    fall_c = -1; rise_c = -1;
    @(negedge clk); start = 1; start_c = cyc;
    @(negedge clk); start = 0;
    chk(error == 0 && done == 0, "R10 start clears flags", int'({done, error}), 0);
    for (int i = 0; i < 60000 && !done; i++) begin
      @(negedge clk);
      start = (poke && i == 3000);
    end
    start = 0;
    parse();
  endtask

  task automatic t_reset();
    chk(panel_rst_n == 1, "R1 panel_rst_n", int'(panel_rst_n), 1);
    chk(ser_req == 0, "R1 ser_req", int'(ser_req), 0);
    chk(done == 0 && error == 0, "R1 done/error", int'({done, error}), 0);
  endtask

  task automatic t_seq_a();
    int exp_cmd [0:9] = '{'h36, 'h3A, 'hB6, 'hC5, 'hE0, 'hE1, 'hB0, 'hB4, 'h29, 'h11};
    int exp_cnt [0:9] = '{1, 1, 4, 2, 16, 16, 1, 1, 0, 0};
    int exp_dly [0:9] = '{0, 0, 0, 0, 0, 20, 0, 100, 100, 0};
    int gap, nrd;
    run(8'h80, -1, -1, 1);
    // R2: reset pulse shape
    chk(fall_c - start_c >= 100*C && fall_c - start_c < 101*C, "R2 first high", fall_c - start_c, 100*C);
    chk(rise_c - fall_c >= 40*C && rise_c - fall_c < 41*C, "R2 low", rise_c - fall_c, 40*C);
    chk(lg_req[0] - rise_c >= 100*C && lg_req[0] - rise_c < 101*C, "R2 second high", lg_req[0] - rise_c, 100*C);
    // R3: identification read first, only once
    chk(lg_rd[0] && !lg_dc[0] && lg_data[0] == 8'h04, "R3 id read word", int'(lg_data[0]), 'h04);
    nrd = 0;
    for (int i = 1; i < nlog; i++) if (lg_rd[i]) nrd++;
    chk(nrd == 0, "R3 single read", nrd, 0);
    // R4 / R5: order and counts; R12: mid-run start had no effect
    chk(nlog == 53, "R12 word count with extra start", nlog, 53);
    chk(ncmd == 10, "R4 command count", ncmd, 10);
    for (int k = 0; k < 10 && k < ncmd; k++) begin
      chk(cmd_v[k] == exp_cmd[k], "R4 command order", cmd_v[k], exp_cmd[k]);
      chk(cmd_n[k] == exp_cnt[k], "R5 parameter count", cmd_n[k], exp_cnt[k]);
    end
    // R7: waits between entries
    for (int k = 1; k < 10 && k < ncmd; k++) begin
      gap = lg_req[cmd_w[k]] - lg_ack[cmd_last[k-1]];
      if (exp_dly[k-1] == 0)
        chk(gap < C, "R7 no wait", gap, 0);
      else
        chk(gap >= exp_dly[k-1]*C && gap < (exp_dly[k-1]+1)*C, "R7 wait", gap, exp_dly[k-1]*C);
    end
    chk(done == 1 && error == 0, "R9 done clean", int'({done, error}), 2);
    repeat (20) @(negedge clk);
    chk(done == 1 && ser_req == 0, "R9 done held", int'({done, ser_req}), 2);
  endtask

  task automatic t_seq_b();
    int total, maxgap, gap;
    run(8'h12, -1, -1, 0);
    chk(ncmd == 24, "R6 command count", ncmd, 24);
    chk(cmd_v[0] == 'hFF && cmd_n[0] == 3, "R3 other id selects second program", cmd_v[0], 'hFF);
    chk(lg_data[cmd_w[0]+1] == 8'hFF && lg_data[cmd_w[0]+2] == 8'h98 && lg_data[cmd_w[0]+3] == 8'h06,
        "R6 first entry params", int'(lg_data[cmd_w[0]+2]), 'h98);
    chk(cmd_v[21] == 'h35 && cmd_n[21] == 1 && lg_data[cmd_w[21]+1] == 8'h00, "R6 last entry", cmd_v[21], 'h35);
    chk(cmd_v[22] == 'h29 && cmd_v[23] == 'h11, "R4 trailer", cmd_v[23], 'h11);
    total = 0;
    for (int k = 0; k < ncmd; k++) total += cmd_n[k];
    chk(total == 108, "R6 parameter total", total, 108);
    maxgap = 0;
    for (int k = 1; k < 23; k++) begin
      gap = lg_req[cmd_w[k]] - lg_ack[cmd_last[k-1]];
      if (gap > maxgap) maxgap = gap;
    end
    chk(maxgap < C, "R7 no waits in second program", maxgap, 0);
    gap = lg_req[cmd_w[23]] - lg_ack[cmd_last[22]];
    chk(gap >= 100*C && gap < 101*C, "R7 wait after 0x29", gap, 100*C);
    chk(done == 1 && error == 0, "R9 done second program", int'({done, error}), 2);
  endtask

  task automatic t_err();
    run(8'h80, 13, -1, 0);
    chk(cmd_v[4] == 'hE0 && cmd_n[4] == 0, "R10 params skipped", cmd_n[4], 0);
    chk(cmd_v[5] == 'hE1 && cmd_n[5] == 16, "R10 next entry runs", cmd_v[5], 'hE1);
    chk(nlog == 37, "R10 word count", nlog, 37);
    chk(error == 1 && done == 1, "R10 error and done", int'({done, error}), 3);
  endtask

  task automatic t_timeout();
    run(8'h80, -1, 13, 0);
    chk(lg_hung[13] && lg_ack[13] - lg_req[13] <= WD + 1, "R11 request withdrawn", lg_ack[13] - lg_req[13], WD);
    chk(cmd_v[4] == 'hE0 && cmd_n[4] == 0 && cmd_v[5] == 'hE1, "R11 continues", cmd_v[5], 'hE1);
    chk(error == 1 && done == 1, "R11 error and done", int'({done, error}), 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1; start = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    repeat (20) @(negedge clk);
    chk(ser_req == 0 && panel_rst_n == 1, "R1 idle without start", int'(ser_req), 0);
    t_seq_a();
    t_seq_b();
    t_err();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule